// File: doc/BRIEF.md
# Two-Phase Instruction Timing Sequencer

This block generates the timing for a processor that spends two phases on every instruction: a fetch phase and an execute phase. It has four outputs. Each phase has a level that stays high for the whole phase, plus a one-cycle write strobe that fires in the phase's final cycle. Downstream registers load on that strobe. Everything runs on one free-running clock. One internal phase bit flips at the end of each phase, so fetch and execute alternate: fetch level, fetch write, execute level, execute write.

A run request starts the sequence from the stopped state, always at fetch. A halt request stops it only at an instruction boundary. If halt arrives at any point in an instruction, that instruction still finishes its execute write, and all outputs drop on the following cycle. When run and halt are raised together while the block is stopped, it stays stopped. A run request while the sequence is already running changes nothing.

The parameter `PHASE_LEN` sets how many clock cycles each phase lasts (default 2, minimum 2).

Top module: `phase_gen`

## Requirements
- R1: While reset (`rst_ni` low) is applied, and on the first cycle after it, all four outputs are low and the block is stopped.
- R2: When stopped, a cycle with `run_i` high and `halt_i` low starts the sequence. `fetch_o` is high in the next cycle.
- R3: Once running, each phase lasts `PHASE_LEN` cycles with its level high throughout. After the last fetch cycle comes the first execute cycle, and after the last execute cycle comes the first fetch cycle.
- R4: `fetch_wr_o` is high only in the last cycle of a fetch phase, and `exec_wr_o` only in the last cycle of an execute phase. Each strobe lasts one cycle per phase.
- R5: `fetch_o` and `exec_o` are never high together, and a write strobe is never high without its own phase level.
- R6: A `halt_i` cycle while fetch or execute is in progress lets the current instruction run through its execute write. All four outputs are low from the next cycle on.
- R7: While stopped, a cycle with both `run_i` and `halt_i` high leaves the block stopped.
- R8: After a halt, the next run restarts at fetch: from the stopped state the first active output is `fetch_o`, never `exec_o`.
- R9: `run_i` while running has no effect on the phase sequence.
- R10: A `halt_i` in the execute write cycle itself stops the block right after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start request, sampled each cycle |
| halt_i | input | 1 | Stop request, honoured at instruction end |
| fetch_o | output | 1 | Fetch phase level |
| fetch_wr_o | output | 1 | Fetch write strobe, last fetch cycle |
| exec_o | output | 1 | Execute phase level |
| exec_wr_o | output | 1 | Execute write strobe, last execute cycle |

## Verification
The assertions check these properties on every cycle:
- The two levels are mutually exclusive, and each strobe sits inside its own level.
- Each strobe lasts a single cycle and is followed by the other phase or by idle.
- The stopped state can only be left through fetch.
- Run and halt together keep the block idle.
- A halt in the execute write cycle stops it.

Some behaviours cannot be stated as simple per-cycle properties, and only the bench's scenarios and its cycle-accurate reference model show them:
- The exact length of each phase.
- A halt raised early in an instruction being held back until the execute write.
- Run having no effect while running.
- Correct recovery after a reset in the middle of an instruction.

// File: rtl/phase_gen_pkg.sv
package phase_gen_pkg;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

endpackage

// File: rtl/phase_gen_runctl.sv
module phase_gen_runctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic halt_i,
    input  logic cycle_end_i,
    output logic running_o
);

    typedef struct packed {
        logic running;
        logic pend;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (!ctl_q.running) begin
            // stopped: halt beats run (R7)
            ctl_d.running = run_i & ~halt_i;
            ctl_d.pend    = 1'b0;
        end else if (cycle_end_i) begin
            // instruction boundary: honour a halt seen now or earlier (R6, R10)
            if (halt_i || ctl_q.pend) begin
                ctl_d.running = 1'b0;
            end
            ctl_d.pend = 1'b0;
        end else begin
            ctl_d.pend = ctl_q.pend | halt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign running_o = ctl_q.running;

endmodule

// File: rtl/phase_gen_step.sv
module phase_gen_step
    import phase_gen_pkg::*;
#(
    parameter int PHASE_LEN = 2
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   active_i,
    output phase_e phase_o,
    output logic   last_o
);

    localparam int SW = (PHASE_LEN > 2) ? $clog2(PHASE_LEN) : 1;
    localparam logic [SW-1:0] LAST = SW'(PHASE_LEN - 1);

    typedef struct packed {
        phase_e        phase;
        logic [SW-1:0] sub;
    } step_t;

    step_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            // idle: park at the start of fetch (R8)
            st_d.phase = PH_FETCH;
            st_d.sub   = '0;
        end else if (st_q.sub == LAST) begin
            st_d.sub   = '0;
            st_d.phase = (st_q.phase == PH_FETCH) ? PH_EXEC : PH_FETCH;
        end else begin
            st_d.sub = st_q.sub + SW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_FETCH, sub: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign last_o  = (st_q.sub == LAST);

endmodule

// File: rtl/phase_gen_strobe.sv
module phase_gen_strobe
    import phase_gen_pkg::*;
(
    input  logic       running_i,
    input  phase_e     phase_i,
    input  logic       last_i,
    output logic [1:0] level_o,
    output logic [1:0] wr_o
);

    for (genvar g = 0; g < 2; g++) begin : g_phase
        localparam phase_e SEL = (g == 0) ? PH_FETCH : PH_EXEC;
        assign level_o[g] = running_i & (phase_i == SEL);
        assign wr_o[g]    = level_o[g] & last_i;
    end

endmodule

// File: rtl/phase_gen.sv
module phase_gen
    import phase_gen_pkg::*;
#(
    parameter int PHASE_LEN = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic halt_i,
    output logic fetch_o,
    output logic fetch_wr_o,
    output logic exec_o,
    output logic exec_wr_o
);

    logic       running;
    phase_e     phase;
    logic       last;
    logic       cycle_end;
    logic [1:0] level;
    logic [1:0] wr;

    assign cycle_end = running & (phase == PH_EXEC) & last;

    phase_gen_runctl u_runctl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run_i),
        .halt_i      (halt_i),
        .cycle_end_i (cycle_end),
        .running_o   (running)
    );

    phase_gen_step #(.PHASE_LEN(PHASE_LEN)) u_step (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (running),
        .phase_o  (phase),
        .last_o   (last)
    );

    phase_gen_strobe u_strobe (
        .running_i (running),
        .phase_i   (phase),
        .last_i    (last),
        .level_o   (level),
        .wr_o      (wr)
    );

    assign fetch_o    = level[0];
    assign exec_o     = level[1];
    assign fetch_wr_o = wr[0];
    assign exec_wr_o  = wr[1];

endmodule

// File: rtl/phase_gen_chk.sv
module phase_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic run_i,
    input logic halt_i,
    input logic fetch_o,
    input logic fetch_wr_o,
    input logic exec_o,
    input logic exec_wr_o
);

    AST_LEVEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({fetch_o, exec_o}));                                          // R5

    AST_WR_IN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_wr_o |-> fetch_o) and (exec_wr_o |-> exec_o));                 // R5

    AST_FETCH_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_wr_o |=> (!fetch_wr_o && exec_o));                              // R4

    AST_EXEC_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_wr_o |=> (!exec_wr_o && !exec_o));                               // R4

    AST_EXEC_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(exec_o) |-> $past(fetch_wr_o));                                  // R3

    AST_IDLE_TO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fetch_o && !exec_o) |=> !exec_o);                                    // R8

    AST_HALT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fetch_o && !exec_o && halt_i) |=> (!fetch_o && !exec_o));            // R7

    AST_HALT_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_wr_o && halt_i) |=> (!fetch_o && !exec_o));                      // R10

    AST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fetch_o && !exec_o && run_i && !halt_i) |=> fetch_o);                // R2

endmodule

bind phase_gen phase_gen_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .halt_i     (halt_i),
    .fetch_o    (fetch_o),
    .fetch_wr_o (fetch_wr_o),
    .exec_o     (exec_o),
    .exec_wr_o  (exec_wr_o)
);

// File: tb/phase_gen_tb_top.sv
`timescale 1ns/1ps
module phase_gen_tb_top;

    localparam int L = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic halt = 1'b0;
    logic fetch, fetch_wr, exec, exec_wr;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    phase_gen #(.PHASE_LEN(L)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .run_i      (run),
        .halt_i     (halt),
        .fetch_o    (fetch),
        .fetch_wr_o (fetch_wr),
        .exec_o     (exec),
        .exec_wr_o  (exec_wr)
    );

    // behavioural reference: position 0..2L-1 inside an instruction
    bit m_on = 0;
    bit m_pend = 0;
    int m_pos = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_on = 0; m_pend = 0; m_pos = 0;
        end else if (!m_on) begin
            if (run && !halt) begin
                m_on = 1; m_pos = 0;
            end
            m_pend = 0;
        end else if (m_pos == 2*L-1) begin
            if (halt || m_pend) m_on = 0;
            m_pend = 0;
            m_pos = 0;
        end else begin
            m_pos++;
            if (halt) m_pend = 1;
        end
    end

    function automatic logic [3:0] model_out();
        logic [3:0] v;
        v[3] = m_on && (m_pos < L);
        v[2] = m_on && (m_pos == L-1);
        v[1] = m_on && (m_pos >= L);
        v[0] = m_on && (m_pos == 2*L-1);
        return v;
    endfunction

    always @(negedge clk) begin
        logic [3:0] act, exp;
        act = {fetch, fetch_wr, exec, exec_wr};
        exp = model_out();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s model compare: actual=%b expected=%b at %0t", cur_req, act, exp, $time);
        end
    end

    task automatic cyc(input logic r, input logic h);
        @(posedge clk);
        #2;
        run = r;
        halt = h;
        @(negedge clk);
        #1;
    endtask

    task automatic chk4(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {fetch, fetch_wr, exec, exec_wr};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cur_req = "R1";
        cyc(0, 0); chk4("R1 in reset", 4'b0000);
        cyc(1, 0); chk4("R1 run ignored in reset", 4'b0000);
        @(posedge clk); #2; rst_n = 1'b1; run = 0;
        cyc(0, 0); chk4("R1 after reset", 4'b0000);

        cur_req = "R2";
        cyc(1, 0); chk4("R2 run sampled next edge", 4'b0000);
        cyc(0, 0); chk4("R2 fetch starts", 4'b1000);
        cur_req = "R3";
        cyc(0, 0); chk4("R4 fetch write", 4'b1100);
        cyc(0, 0); chk4("R3 execute follows", 4'b0010);
        cyc(0, 0); chk4("R4 execute write", 4'b0011);
        cyc(0, 0); chk4("R3 fetch again", 4'b1000);

        cur_req = "R9";
        cyc(1, 0); chk4("R9 run while running", 4'b1100);
        cyc(1, 0); chk4("R9 sequence unchanged", 4'b0010);
        cyc(0, 0); chk4("R9 execute write", 4'b0011);
        cyc(0, 0); chk4("R9 fetch", 4'b1000);

        cur_req = "R6";
        cyc(0, 1); chk4("R6 halt during fetch", 4'b1100);
        cyc(0, 0); chk4("R6 execute still runs", 4'b0010);
        cyc(0, 0); chk4("R6 execute write completes", 4'b0011);
        cyc(0, 0); chk4("R6 stopped after", 4'b0000);
        cyc(0, 0); chk4("R6 stays stopped", 4'b0000);

        cur_req = "R8";
        cyc(1, 0); chk4("R8 idle before restart", 4'b0000);
        cyc(0, 0); chk4("R8 restart at fetch", 4'b1000);
        cyc(0, 0); chk4("R8 fetch write", 4'b1100);
        cyc(0, 0); chk4("R8 execute", 4'b0010);

        cur_req = "R10";
        cyc(0, 1); chk4("R10 halt in execute write", 4'b0011);
        cyc(0, 0); chk4("R10 stopped next cycle", 4'b0000);

        cur_req = "R7";
        cyc(1, 1); chk4("R7 run and halt", 4'b0000);
        cyc(0, 0); chk4("R7 still stopped", 4'b0000);
        cyc(0, 0); chk4("R7 still stopped later", 4'b0000);

        cur_req = "R1";
        cyc(1, 0); chk4("R2 second start", 4'b0000);
        cyc(0, 0); chk4("R2 fetch", 4'b1000);
        cyc(0, 0); chk4("R4 fetch write", 4'b1100);
        cyc(0, 0); chk4("R3 execute", 4'b0010);
        @(posedge clk); #2; rst_n = 1'b0;
        @(negedge clk); #1; chk4("R1 reset mid execute", 4'b0000);
        @(posedge clk); #2; rst_n = 1'b1;
        cyc(0, 0); chk4("R1 idle after reset", 4'b0000);

        cur_req = "R3";
        for (int i = 0; i < 12; i++) cyc(1, 0);
        cur_req = "R5";
        for (int i = 0; i < 400; i++) begin
            logic r, h;
            r = ($urandom_range(0, 3) != 0);
            h = ($urandom_range(0, 5) == 0);
            cyc(r, h);
        end
        cyc(0, 1);
        for (int i = 0; i < 2*L+1; i++) cyc(0, 0);
        chk4("R6 halted at end", 4'b0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule